// File: doc/BRIEF.md
# Time-Locked Pulse-Train Generator

This block drives up to four periodic output pulses whose first edge is tied to an external system time made of a seconds count and a sub-second count. For each output, software programs a target time, an interval and a high width, then writes a command into one shared control word. When the system time reaches the target, the output starts a train. Each period lasts a set number of sub-second increment ticks, and the output stays high for a set number of ticks at the start of each period.

Interval and width are both stored as the tick count minus one. The block does not count time itself. It takes the running time and a one-cycle tick strobe from a time counter outside the block, and it counts the strobes. Registers are reached through a plain single-cycle write port and a combinational read port.

Register map: control word at 0x00; read-only capability word at 0x04; output n has four words starting at 0x20 + 0x10·n. Those four words are, in order: target seconds (+0x0), target sub-seconds (+0x4), interval (+0x8) and width (+0xC).

Top module: `pulse_train_gen`

## Requirements
- R1: After reset all pulse outputs are low, the control word reads 0, every busy flag is clear, and the capability word reads the number of outputs in bits [26:24] with all other bits zero. Writes to the capability word have no effect.
- R2: Control byte n occupies bits [8n+7:8n]. Within it, bits [3:0] hold a command, bits [6:5] a mode select and bit 7 a multi-output enable. Bit 4 of the whole word is the global enable. Mode, multi-output enable and global enable read back as written. A command field reads back its written value in the cycle after the write and reads 0 from the following cycle on.
- R3: Command 0x2 is a start. It is accepted only while that output is not busy. Once accepted, it sets the busy flag, which is bit 31 of the target sub-seconds word, at the second clock edge after the control write.
- R4: A start is refused, and the busy flag stays clear, while the interval register holds 0.
- R5: A busy output compares {seconds, sub-seconds} against its target, with seconds weighing more. At the first clock edge where the time is greater than or equal to the target, the busy flag clears and the output goes high straight after that edge.
- R6: While a train runs, each period lasts interval+1 tick strobes. The output is high for the first width+1 strobes of each period. Without tick strobes the output holds its level.
- R7: Writes to the target seconds or target sub-seconds word are refused while the busy flag is set. This includes the clock edge on which the flag clears.
- R8: Command 0x5 is a stop. On a running train it lets the current period finish and then holds the output low with no further rising edge. On a busy output it cancels the pending start, and no pulse follows.
- R9: Clearing the global enable forces every pulse output low without stopping the trains. Setting it again brings the pulses back in step with the running trains.
- R10: Outputs run independently. Two outputs started by one control write each begin at their own target time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address (read and write) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| tick_i | input | 1 | One-cycle strobe per sub-second increment |
| sys_sec_i | input | 32 | System time, seconds |
| sys_sub_i | input | 31 | System time, sub-seconds |
| pulse_o | output | NUM_OUT | Pulse outputs, bit n for output n |

## Verification
Two events are made to land on one clock edge: the system time reaching the target, and a software write to the target sub-seconds word. The bench freezes the time input and holds it at the target while it issues that write. It then reads back the old target with busy clear and sees the pulse high, which shows the time match wins and the write is refused. A second pairing lets a stop command arrive partway through a period. The bench requires that period's high phase to run its full width and that no rising edge follows.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    localparam int DATA_W  = 32;
    localparam int SEC_W   = 32;
    localparam int SUB_W   = 31;
    localparam int ADDR_W  = 8;
    localparam int MAX_OUT = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_CAP  = 8'h04;
    localparam logic [ADDR_W-1:0] CH_BASE   = 8'h20;

    typedef enum logic [3:0] {
        CMD_NONE  = 4'h0,
        CMD_START = 4'h2,
        CMD_STOP  = 4'h5
    } cmd_e;

    typedef enum logic [1:0] {
        REG_TSEC = 2'd0,
        REG_TSUB = 2'd1,
        REG_IVL  = 2'd2,
        REG_WID  = 2'd3
    } chreg_e;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
    } systime_t;

    typedef struct packed {
        logic       multi;
        logic [1:0] mode;
    } chcfg_t;

    function automatic logic time_reached(input systime_t now, input systime_t tgt);
        return now >= tgt;
    endfunction

endpackage

// File: rtl/ptg_ctrl.sv
module ptg_ctrl
    import ptg_pkg::*;
#(
    parameter int NUM_OUT = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 wr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic                 glob_en_o,
    output logic [NUM_OUT-1:0]   start_o,
    output logic [NUM_OUT-1:0]   stop_o,
    output logic [DATA_W-1:0]    rd_o
);

    logic [3:0] cmd_q [NUM_OUT];
    chcfg_t     cfg_q [NUM_OUT];
    logic       glob_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)      glob_q <= 1'b0;
        else if (wr_i)  glob_q <= wdata_i[4];
    end

    for (genvar n = 0; n < NUM_OUT; n++) begin : g_byte
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                cmd_q[n] <= CMD_NONE;
                cfg_q[n] <= '0;
            end else if (wr_i) begin
                cmd_q[n] <= wdata_i[8*n +: 4];
                cfg_q[n] <= chcfg_t'({wdata_i[8*n+7], wdata_i[8*n+6 -: 2]});
            end else begin
                cmd_q[n] <= CMD_NONE;
            end
        end

        assign start_o[n] = (cmd_q[n] == CMD_START);
        assign stop_o[n]  = (cmd_q[n] == CMD_STOP);

        // R2
        cmd_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (cmd_q[n] != 4'h0 && !wr_i) |=> (cmd_q[n] == 4'h0));
    end

    always_comb begin
        rd_o = '0;
        for (int n = 0; n < NUM_OUT; n++) begin
            rd_o[8*n +: 8] = {cfg_q[n].multi, cfg_q[n].mode, 1'b0, cmd_q[n]};
        end
        rd_o[4] = glob_q;
    end

    assign glob_en_o = glob_q;

endmodule

// File: rtl/ptg_channel.sv
module ptg_channel
    import ptg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              glob_en_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  systime_t          now_i,
    input  logic              tick_i,
    input  logic              wr_i,
    input  chreg_e            sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rd_o,
    output logic              pulse_o
);

    systime_t          tgt_q;
    logic [DATA_W-1:0] ivl_q;
    logic [DATA_W-1:0] wid_q;
    logic [DATA_W-1:0] cnt_q;
    logic              busy_q;
    logic              run_q;
    logic              stop_pend_q;

    logic start_ok;
    logic reach;
    logic period_end;
    logic tgt_wr_ok;

    assign tgt_wr_ok  = wr_i && !busy_q;
    assign start_ok   = start_i && !busy_q && (ivl_q != '0);
    assign reach      = busy_q && time_reached(now_i, tgt_q);
    assign period_end = run_q && tick_i && (cnt_q >= ivl_q);

    // register file
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tgt_q <= '0;
            ivl_q <= '0;
            wid_q <= '0;
        end else if (wr_i) begin
            case (sel_i)
                REG_TSEC: if (tgt_wr_ok) tgt_q.sec <= wdata_i;
                REG_TSUB: if (tgt_wr_ok) tgt_q.sub <= wdata_i[SUB_W-1:0];
                REG_IVL:  ivl_q <= wdata_i;
                REG_WID:  wid_q <= wdata_i;
                default:  ;
            endcase
        end
    end

    // train engine
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q      <= 1'b0;
            run_q       <= 1'b0;
            stop_pend_q <= 1'b0;
            cnt_q       <= '0;
        end else if (start_ok) begin
            busy_q      <= 1'b1;
            run_q       <= 1'b0;
            stop_pend_q <= 1'b0;
            cnt_q       <= '0;
        end else if (stop_i && busy_q) begin
            busy_q      <= 1'b0;
        end else if (reach) begin
            busy_q      <= 1'b0;
            run_q       <= 1'b1;
            stop_pend_q <= 1'b0;
            cnt_q       <= '0;
        end else if (run_q) begin
            if (period_end) begin
                cnt_q <= '0;
                if (stop_pend_q || stop_i) begin
                    run_q       <= 1'b0;
                    stop_pend_q <= 1'b0;
                end
            end else begin
                if (tick_i) cnt_q <= cnt_q + 1'b1;
                if (stop_i) stop_pend_q <= 1'b1;
            end
        end
    end

    assign pulse_o = glob_en_i && run_q && (cnt_q <= wid_q);

    always_comb begin
        case (sel_i)
            REG_TSEC: rd_o = tgt_q.sec;
            REG_TSUB: rd_o = {busy_q, tgt_q.sub};
            REG_IVL:  rd_o = ivl_q;
            default:  rd_o = wid_q;
        endcase
    end

    logic unused_wbit;
    assign unused_wbit = wdata_i[DATA_W-1];

    // R7
    tgt_lock_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && busy_q) |=> $stable(tgt_q));

    // R5
    reach_go_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (reach && !stop_i) |=> (run_q && !busy_q));

    // R5
    busy_run_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(busy_q && run_q));

    // R4
    ivl_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !busy_q && ivl_q == '0) |=> !busy_q);

    // R9
    pulse_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> (glob_en_i && run_q));

    // R8
    stop_cancel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (stop_i && busy_q) |=> (!busy_q && !run_q));

endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen
    import ptg_pkg::*;
#(
    parameter int NUM_OUT = 4
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               wr_en_i,
    input  logic [7:0]         addr_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    input  logic               tick_i,
    input  logic [31:0]        sys_sec_i,
    input  logic [30:0]        sys_sub_i,
    output logic [NUM_OUT-1:0] pulse_o
);

    localparam logic [3:0] IDX_LIM = 4'(NUM_OUT);
    localparam logic [2:0] CAP_VAL = 3'(NUM_OUT);

    logic [7:0] ch_off;
    logic [3:0] ch_idx;
    logic       ch_hit;
    chreg_e     ch_sel;
    logic       ctrl_wr;

    logic               glob_en;
    logic [NUM_OUT-1:0] start_v;
    logic [NUM_OUT-1:0] stop_v;
    logic [31:0]        ctrl_rd;
    logic [31:0]        ch_rd [NUM_OUT];
    systime_t           now;

    assign ch_off  = addr_i - CH_BASE;
    assign ch_idx  = ch_off[7:4];
    assign ch_hit  = (addr_i >= CH_BASE) && (ch_idx < IDX_LIM);
    assign ch_sel  = chreg_e'(ch_off[3:2]);
    assign ctrl_wr = wr_en_i && (addr_i == ADDR_CTRL);
    assign now     = '{sec: sys_sec_i, sub: sys_sub_i};

    logic [1:0] unused_lsb;
    assign unused_lsb = ch_off[1:0];

    ptg_ctrl #(.NUM_OUT(NUM_OUT)) ctrl_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_i      (ctrl_wr),
        .wdata_i   (wdata_i),
        .glob_en_o (glob_en),
        .start_o   (start_v),
        .stop_o    (stop_v),
        .rd_o      (ctrl_rd)
    );

    for (genvar n = 0; n < NUM_OUT; n++) begin : g_ch
        logic ch_wr;
        assign ch_wr = wr_en_i && ch_hit && (ch_idx == 4'(n));

        ptg_channel chan_i (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .glob_en_i (glob_en),
            .start_i   (start_v[n]),
            .stop_i    (stop_v[n]),
            .now_i     (now),
            .tick_i    (tick_i),
            .wr_i      (ch_wr),
            .sel_i     (ch_sel),
            .wdata_i   (wdata_i),
            .rd_o      (ch_rd[n]),
            .pulse_o   (pulse_o[n])
        );
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_CTRL) begin
            rdata_o = ctrl_rd;
        end else if (addr_i == ADDR_CAP) begin
            rdata_o = {5'b0, CAP_VAL, 24'b0};
        end else if (ch_hit) begin
            for (int n = 0; n < NUM_OUT; n++) begin
                if (ch_idx == 4'(n)) rdata_o = ch_rd[n];
            end
        end
    end

    // R1
    cap_const_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (addr_i == ADDR_CAP) |-> (rdata_o[26:24] == CAP_VAL && rdata_o[23:0] == '0));

endmodule

// File: tb/pulse_train_gen_tb.sv
`timescale 1ns/1ps
module pulse_train_gen_tb_top;

    localparam int NOUT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        run_time = 1'b0;
    logic [31:0] sec = '0;
    logic [30:0] sub = '0;
    logic [NOUT-1:0] pulse;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    pulse_train_gen #(.NUM_OUT(NOUT)) dut_i (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .tick_i(run_time),
        .sys_sec_i(sec), .sys_sub_i(sub), .pulse_o(pulse)
    );

    // vector table: channel, interval(minus one), width(minus one), start delay
    localparam int NV = 4;
    localparam int V_CH  [NV] = '{0, 1, 2, 3};
    localparam int V_IVL [NV] = '{9, 5, 3, 7};
    localparam int V_WID [NV] = '{4, 2, 1, 0};
    localparam int V_DLY [NV] = '{12, 10, 15, 11};

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_cycle();
        @(posedge clk);
        #1;
        if (run_time) sub = sub + 31'd1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick_cycle();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    function automatic logic [7:0] cha(input int ch, input int r);
        return 8'(32 + 16 * ch + 4 * r);
    endfunction

    // mode 2, multi enable in every byte; global enable bit 4
    function automatic logic [31:0] cw(input int ch_a, input int cmd_a,
                                       input int ch_b, input int cmd_b, input bit glob);
        logic [31:0] w;
        w = 32'hC0C0C0C0;
        if (ch_a >= 0) w[8*ch_a +: 4] = 4'(cmd_a);
        if (ch_b >= 0) w[8*ch_b +: 4] = 4'(cmd_b);
        w[4] = glob;
        return w;
    endfunction

    task automatic wait_rise(input int ch, input int lim, output bit seen);
        seen = 1'b0;
        for (int k = 0; k < lim; k++) begin
            tick_cycle();
            if (pulse[ch]) begin seen = 1'b1; break; end
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        bit seen;
        int s, h, l, highs, rises;
        logic prev;

        // ---------- reset (R1) ----------
        repeat (3) tick_cycle();
        rst = 1'b0;
        tick_cycle();
        check("R1 pulses low", pulse, 0);
        rd(8'h00, d); check("R1 ctrl zero", d, 0);
        rd(8'h04, d); check("R1 capability", d, 32'(NOUT) << 24);
        rd(cha(0, 1), d); check("R1 busy clear", d[31], 0);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, d); check("R1 capability read-only", d, 32'(NOUT) << 24);

        // ---------- table walk (R3 R5 R6 R8) ----------
        run_time = 1'b1;
        for (int v = 0; v < NV; v++) begin
            s = int'(sub) + V_DLY[v];
            wr(cha(V_CH[v], 0), 32'd0);
            wr(cha(V_CH[v], 1), 32'(s));
            wr(cha(V_CH[v], 2), 32'(V_IVL[v]));
            wr(cha(V_CH[v], 3), 32'(V_WID[v]));
            wr(8'h00, cw(V_CH[v], 2, -1, 0, 1'b1));
            tick_cycle();
            rd(cha(V_CH[v], 1), d); check("R3 busy after start", d[31], 1);
            wait_rise(V_CH[v], 100, seen);
            check("R5 rise seen", seen, 1);
            check("R5 rise time", sub, s + 1);
            rd(cha(V_CH[v], 1), d); check("R5 busy cleared", d[31], 0);
            h = 1;
            while (h < 200) begin tick_cycle(); if (!pulse[V_CH[v]]) break; h++; end
            l = 1;
            while (l < 200) begin tick_cycle(); if (pulse[V_CH[v]]) break; l++; end
            check("R6 high length", h, V_WID[v] + 1);
            check("R6 period length", h + l, V_IVL[v] + 1);
            // stop right after a rising edge
            highs = 1; rises = 0; prev = 1'b1;
            wr(8'h00, cw(V_CH[v], 5, -1, 0, 1'b1));
            if (pulse[V_CH[v]]) highs++;
            prev = pulse[V_CH[v]];
            for (int k = 0; k < 3 * (V_IVL[v] + 1); k++) begin
                tick_cycle();
                if (pulse[V_CH[v]]) highs++;
                if (pulse[V_CH[v]] && !prev) rises++;
                prev = pulse[V_CH[v]];
            end
            check("R8 last period high length", highs, V_WID[v] + 1);
            check("R8 no rise after stop", rises, 0);
        end

        // ---------- R2 control readback ----------
        wr(8'h00, cw(3, 5, -1, 0, 1'b1));
        rd(8'h00, d); check("R2 command visible next cycle", d, 32'hC5C0C0D0);
        tick_cycle();
        rd(8'h00, d); check("R2 command self-clears", d, 32'hC0C0C0D0);

        // ---------- R4 interval zero refuses start ----------
        wr(cha(1, 2), 32'd0);
        wr(cha(1, 1), 32'(int'(sub) + 5));
        wr(8'h00, cw(1, 2, -1, 0, 1'b1));
        tick_cycle();
        rd(cha(1, 1), d); check("R4 busy stays clear", d[31], 0);
        highs = 0;
        for (int k = 0; k < 20; k++) begin tick_cycle(); if (pulse[1]) highs++; end
        check("R4 no pulse", highs, 0);

        // ---------- R10 two outputs from one write ----------
        s = int'(sub) + 10;
        wr(cha(0, 0), 0); wr(cha(0, 1), 32'(s)); wr(cha(0, 2), 20); wr(cha(0, 3), 10);
        wr(cha(2, 0), 0); wr(cha(2, 1), 32'(s + 6)); wr(cha(2, 2), 20); wr(cha(2, 3), 10);
        wr(8'h00, cw(0, 2, 2, 2, 1'b1));
        wait_rise(0, 100, seen);
        check("R10 out0 start time", sub, s + 1);
        check("R10 out2 still low", pulse[2], 0);
        wait_rise(2, 100, seen);
        check("R10 out2 start time", sub, s + 7);
        wr(8'h00, cw(0, 5, 2, 5, 1'b1));
        repeat (30) tick_cycle();
        check("R8 both stopped", pulse & 4'b0101, 0);

        // ---------- R7 same-edge target write vs time match ----------
        run_time = 1'b0;
        sec = 0; sub = 100;
        wr(cha(0, 1), 200); wr(cha(0, 2), 9); wr(cha(0, 3), 4);
        wr(8'h00, cw(0, 2, -1, 0, 1'b1));
        tick_cycle();
        rd(cha(0, 1), d); check("R3 busy while pending", d[31], 1);
        wr(cha(0, 1), 300);
        rd(cha(0, 1), d); check("R7 write refused while busy", d[30:0], 200);
        sub = 200;
        wr(cha(0, 1), 500);
        rd(cha(0, 1), d);
        check("R7 same-edge write refused", d[30:0], 200);
        check("R5 busy clears on match", d[31], 0);
        check("R5 pulse high on match", pulse[0], 1);
        repeat (20) tick_cycle();
        check("R6 no ticks holds level", pulse[0], 1);
        wr(8'h00, cw(0, 5, -1, 0, 1'b1));
        run_time = 1'b1;
        repeat (30) tick_cycle();
        check("R8 stopped after resume", pulse[0], 0);

        // ---------- R5 seconds dominate ----------
        run_time = 1'b0;
        sec = 1; sub = 500;
        wr(cha(1, 2), 5); wr(cha(1, 3), 2);
        wr(cha(1, 0), 2); wr(cha(1, 1), 10);
        wr(8'h00, cw(1, 2, -1, 0, 1'b1));
        repeat (3) tick_cycle();
        rd(cha(1, 1), d); check("R5 lower seconds not reached", d[31], 1);
        sec = 2; sub = 9;
        repeat (2) tick_cycle();
        rd(cha(1, 1), d); check("R5 sub below target not reached", d[31], 1);
        check("R5 no pulse before target", pulse[1], 0);
        sub = 10;
        tick_cycle();
        check("R5 pulse at target", pulse[1], 1);
        wr(8'h00, cw(1, 5, -1, 0, 1'b1));
        run_time = 1'b1;
        repeat (20) tick_cycle();

        // ---------- R8 stop while busy cancels ----------
        run_time = 1'b0;
        wr(cha(2, 0), 2); wr(cha(2, 1), 32'(int'(sub) + 30));
        wr(8'h00, cw(2, 2, -1, 0, 1'b1));
        tick_cycle();
        rd(cha(2, 1), d); check("R8 armed before cancel", d[31], 1);
        wr(8'h00, cw(2, 5, -1, 0, 1'b1));
        tick_cycle();
        rd(cha(2, 1), d); check("R8 cancel clears busy", d[31], 0);
        run_time = 1'b1;
        highs = 0;
        for (int k = 0; k < 60; k++) begin tick_cycle(); if (pulse[2]) highs++; end
        check("R8 cancelled output silent", highs, 0);

        // ---------- R9 global enable ----------
        wr(cha(3, 0), 2); wr(cha(3, 1), 32'(int'(sub) + 12));
        wr(cha(3, 2), 7); wr(cha(3, 3), 3);
        wr(8'h00, cw(3, 2, -1, 0, 1'b1));
        wait_rise(3, 100, seen);
        check("R9 train running", seen, 1);
        wr(8'h00, cw(-1, 0, -1, 0, 1'b0));
        rd(8'h00, d); check("R2 global enable readback", d, 32'hC0C0C0C0);
        highs = 0;
        for (int k = 0; k < 24; k++) begin tick_cycle(); if (pulse[3]) highs++; end
        check("R9 disabled output low", highs, 0);
        wr(8'h00, cw(-1, 0, -1, 0, 1'b1));
        wait_rise(3, 8, seen);
        check("R9 pulse returns", seen, 1);

        summary();
        $finish;
    end

endmodule